// File: doc/BRIEF.md
# Watchdog Two-Stage Timeout Tracker

This block is a software-serviced watchdog with two escalation stages. A down-counter is loaded from a programmable reload value. Each time it reaches zero it expires, reloads itself and keeps counting. The first expiry sets a first-timeout status flag. If the counter expires again while that flag is still set, a second-timeout flag sets. A single-cycle reboot request goes out on that event when the reboot-permit input allows it.

A boot-status flag marks a second timeout that happened after reset but before the system fetched anything from its boot ROM. The ROM fetch is signalled to the block by a strobe input. A halt control freezes the counter, which also keeps both timeout flags from being set. Software reaches the reload value, the control bit, the status flags and the live count through a small register port. It clears status flags by writing ones to them.

Top module: `wdt_two_stage`

## Requirements
- R1: After a synchronous active-low reset, the reload register and the counter hold RELOAD_RST (default 255). Control, all status flags and `reboot_req` are 0.
- R2: When not halted and not being loaded, the counter decreases by one per cycle. In a cycle where it is 0 it expires and takes the reload value at the next edge. The period is therefore reload+1 cycles, and a reload of 0 expires every cycle.
- R3: A write to address 0 (reload register, bits CNT_W-1:0) stores the value and also restarts the counter at that value at the same edge. No expiry happens in that cycle.
- R4: An expiry sets status bit 0, the first-timeout flag.
- R5: An expiry while status bit 0 is already 1 sets status bit 1, the second-timeout flag.
- R6: While control bit 0 (address 1, halt) is 1, the counter holds its value and neither timeout flag can be set.
- R7: Status (address 2) bits are cleared by writing 1 to them. Writing 0 leaves a bit unchanged, and software can never set a bit.
- R8: When a hardware set and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up 1.
- R9: Status bit 2, boot status, sets when bit 1 rises, but only if no `rom_access` strobe was seen in an earlier cycle since reset. A strobe seen after reset blocks it until the next reset.
- R10: `reboot_req` is high for exactly one cycle, the cycle in which status bit 1 first reads 1, and only if `reboot_allow` was 1 during the expiry cycle. It does not pulse again while bit 1 stays set.
- R11: Reading address 3 returns the current counter value in bits CNT_W-1:0. Any register bits that are not defined read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address: 0 reload, 1 control, 2 status, 3 count |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| rom_access | input | 1 | Strobe marking a boot-ROM fetch |
| reboot_allow | input | 1 | Permits the reboot request on a second timeout |
| reboot_req | output | 1 | One-cycle reboot request pulse |

## Verification
Several properties are checked on every cycle by the embedded assertions:
- the counter holds its value under halt, and otherwise decrements or reloads;
- an expiry always leaves the first-timeout flag set;
- the second-timeout flag only rises when the first-timeout flag was already set;
- boot status and the reboot pulse only appear on a rise of the second-timeout flag, and the pulse lasts one cycle.

Other behaviours can only be shown by the bench scenarios:
- the exact cycle of each expiry across a sweep of reload values;
- the blocking of boot status by an earlier ROM strobe;
- a clear that loses to a set in the same cycle;
- the restart caused by a reload write.

// File: rtl/wdt_pkg.sv
// Shared definitions for the two-stage watchdog: register addresses,
// status bit layout and the status record type.
package wdt_pkg;

    localparam int ADDR_W = 2;

    // Register map of the software port.
    typedef enum logic [ADDR_W-1:0] {
        REG_RELOAD = 2'd0,
        REG_CTRL   = 2'd1,
        REG_STATUS = 2'd2,
        REG_COUNT  = 2'd3
    } wdt_reg_e;

    // Control and status bit positions.
    localparam int CTRL_HALT = 0;
    localparam int ST_W      = 3;

    // Status flags; packed so that bit 0 is tmo1, bit 1 tmo2, bit 2 boot.
    typedef struct packed {
        logic boot;
        logic tmo2;
        logic tmo1;
    } wdt_status_t;

endpackage

// File: rtl/wdt_counter.sv
// Down-counter of the watchdog.
// Function: counts down once per cycle. At zero it flags an expiry and
// reloads from the programmed value. A load request restarts it at
// load_val and suppresses the expiry. Halt freezes it.
// Assumes: synchronous active-low reset; load has priority over halt.
module wdt_counter #(
    parameter int CNT_W      = 8,
    parameter int RELOAD_RST = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RELOAD_RST);

    logic at_zero;

    // Detect the terminal count and qualify it as an expiry.
    always_comb begin
        at_zero = (count == '0);
        expire  = at_zero && !halt && !load;
    end

    // Count down, reload on expiry, restart on software load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= RST_VAL;
        end else if (load) begin
            count <= load_val;
        end else if (halt) begin
            count <= count;
        end else if (at_zero) begin
            count <= reload_val;
        end else begin
            count <= count - 1'b1;
        end
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load) |=> (count == $past(count))); // R6

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !load && count != '0) |=> (count == $past(count) - 1'b1)); // R2

    AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == $past(reload_val))); // R2

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val))); // R3

endmodule

// File: rtl/wdt_status.sv
// Status tracker of the watchdog.
// Function: keeps the first-timeout, second-timeout and boot flags and a
// sticky record of ROM access. It also issues a one-cycle reboot pulse
// on the rise of the second-timeout flag.
// Assumes: expire is already blocked while halted. Clears arrive as a
// write-one mask, and a hardware set beats a clear in the same cycle.
module wdt_status
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        expire,
    input  wdt_status_t clr,
    input  logic        rom_access,
    input  logic        reboot_allow,
    output wdt_status_t status,
    output logic        reboot_req
);

    logic set_tmo1;
    logic set_tmo2;
    logic rise_tmo2;
    logic set_boot;
    logic rom_seen;

    // Work out the hardware set conditions for this cycle.
    always_comb begin
        set_tmo1  = expire;
        set_tmo2  = expire && status.tmo1;
        rise_tmo2 = set_tmo2 && !status.tmo2;
        set_boot  = rise_tmo2 && !rom_seen;
    end

    // Status flags: set by hardware, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status.tmo1 <= set_tmo1 || (status.tmo1 && !clr.tmo1);
            status.tmo2 <= set_tmo2 || (status.tmo2 && !clr.tmo2);
            status.boot <= set_boot || (status.boot && !clr.boot);
        end
    end

    // Sticky record of the first ROM strobe since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_seen <= 1'b0;
        end else if (rom_access) begin
            rom_seen <= 1'b1;
        end
    end

    // One-cycle reboot request on the rise of the second-timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reboot_req <= 1'b0;
        end else begin
            reboot_req <= rise_tmo2 && reboot_allow;
        end
    end

    AST_EXPIRY_SETS_TMO1: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status.tmo1); // R4

    AST_TMO2_NEEDS_TMO1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status.tmo2) |-> $past(status.tmo1)); // R5

    AST_BOOT_ON_TMO2_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status.boot) |-> $rose(status.tmo2)); // R9

    AST_BOOT_BLOCKED_BY_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        rom_seen |=> !$rose(status.boot)); // R9

    AST_REBOOT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |-> $rose(status.tmo2)); // R10

    AST_REBOOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |=> !reboot_req); // R10

endmodule

// File: rtl/wdt_regif.sv
// Register port of the watchdog.
// Function: holds the reload value and the halt control, decodes writes
// into a counter restart and a status clear mask, and muxes read data.
// Assumes: single address shared by reads and writes. Reads are
// combinational and have no side effects.
module wdt_regif
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int DATA_W     = 16,
    parameter int RELOAD_RST = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  count,
    input  wdt_status_t       status,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [CNT_W-1:0]  reload_val,
    output logic              halt,
    output logic              load,
    output wdt_status_t       clr
);

    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RELOAD_RST);

    logic wr_reload;
    logic wr_ctrl;
    logic wr_status;

    // Decode write strobes per register.
    always_comb begin
        wr_reload = reg_wr && (reg_addr == REG_RELOAD);
        wr_ctrl   = reg_wr && (reg_addr == REG_CTRL);
        wr_status = reg_wr && (reg_addr == REG_STATUS);
        load      = wr_reload;
        clr       = wr_status ? wdt_status_t'(reg_wdata[ST_W-1:0]) : '0;
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_val <= RST_VAL;
        end else if (wr_reload) begin
            reload_val <= reg_wdata[CNT_W-1:0];
        end
    end

    // Halt control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt <= 1'b0;
        end else if (wr_ctrl) begin
            halt <= reg_wdata[CTRL_HALT];
        end
    end

    // Read data multiplexer; undefined bits read as zero.
    always_comb begin
        reg_rdata = '0;
        case (wdt_reg_e'(reg_addr))
            REG_RELOAD: reg_rdata[CNT_W-1:0]  = reload_val;
            REG_CTRL:   reg_rdata[CTRL_HALT]  = halt;
            REG_STATUS: reg_rdata[ST_W-1:0]   = status;
            REG_COUNT:  reg_rdata[CNT_W-1:0]  = count;
            default:    reg_rdata             = '0;
        endcase
    end

    AST_RELOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_reload |=> $stable(reload_val)); // R3

endmodule

// File: rtl/wdt_two_stage.sv
// Two-stage watchdog top level.
// Function: joins the register port, the down-counter and the status
// tracker. The reboot request leaves directly from the status tracker.
// Assumes: one clock domain; synchronous active-low reset;
// CNT_W >= 3 and CNT_W <= DATA_W.
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int DATA_W     = 16,
    parameter int RELOAD_RST = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rom_access,
    input  logic              reboot_allow,
    output logic              reboot_req
);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] reload_val;
    logic             halt;
    logic             load;
    logic             expire;
    wdt_status_t      status;
    wdt_status_t      clr;

    // Register port.
    wdt_regif #(
        .CNT_W      (CNT_W),
        .DATA_W     (DATA_W),
        .RELOAD_RST (RELOAD_RST)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .count      (count),
        .status     (status),
        .reg_rdata  (reg_rdata),
        .reload_val (reload_val),
        .halt       (halt),
        .load       (load),
        .clr        (clr)
    );

    // Down-counter.
    wdt_counter #(
        .CNT_W      (CNT_W),
        .RELOAD_RST (RELOAD_RST)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt       (halt),
        .load       (load),
        .load_val   (reg_wdata[CNT_W-1:0]),
        .reload_val (reload_val),
        .count      (count),
        .expire     (expire)
    );

    // Status tracker.
    wdt_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .expire       (expire),
        .clr          (clr),
        .rom_access   (rom_access),
        .reboot_allow (reboot_allow),
        .status       (status),
        .reboot_req   (reboot_req)
    );

    AST_HALT_BLOCKS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!$rose(status.tmo1) && !$rose(status.tmo2))); // R6

    AST_SW_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        !expire |=> !$rose(status.tmo1)); // R7

endmodule

// File: tb/tb_wdt_two_stage.sv
// Self-checking bench: sweeps reload values and checks count, status and
// reboot pulse on every cycle against an arithmetic model, then runs
// directed cases for ROM blocking, halt, clearing, set priority and restart.
module tb_wdt_two_stage;

    localparam int CNT_W  = 8;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic              reg_wr = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              rom_access = 1'b0;
    logic              reboot_allow = 1'b0;
    logic              reboot_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    wdt_two_stage #(.CNT_W(CNT_W), .DATA_W(DATA_W), .RELOAD_RST(255)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .rom_access   (rom_access),
        .reboot_allow (reboot_allow),
        .reboot_req   (reboot_req)
    );

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        reg_addr  = addr[1:0];
        reg_wdata = data[DATA_W-1:0];
        reg_wr    = 1'b1;
        step();
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        reg_addr = addr[1:0];
        #1;
        data = int'(reg_rdata);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rom_access = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        int v;
        int c0;
        // R1: reset state
        do_reset();
        rd(0, v); check("R1 reload", v, 255);
        rd(3, v); check("R1 count", v, 255);
        rd(1, v); check("R1 ctrl", v, 0);
        rd(2, v); check("R1 status", v, 0);
        check("R1 reboot", int'(reboot_req), 0);

        // Sweep reload values; R2 R4 R5 R9 R10 R11 per cycle
        for (int r = 0; r <= 5; r++) begin
            do_reset();
            reboot_allow = (r % 2 == 0);
            wr(0, r);
            for (int k = 0; k <= 3 * r + 5; k++) begin
                int ecnt;
                int est;
                ecnt = r - (k % (r + 1));
                est  = ((k >= r + 1) ? 1 : 0) + ((k >= 2 * r + 2) ? 6 : 0);
                rd(3, v); check("R2/R11 count", v, ecnt);
                rd(2, v); check("R4/R5/R9 status", v, est);
                check("R10 reboot", int'(reboot_req),
                      (reboot_allow && k == 2 * r + 2) ? 1 : 0);
                step();
            end
        end

        // R9: an earlier ROM strobe blocks boot status
        do_reset();
        reboot_allow = 1'b1;
        rom_access = 1'b1;
        step();
        rom_access = 1'b0;
        wr(0, 2);
        repeat (6) step();
        rd(2, v); check("R9 boot blocked", v, 3);
        check("R10 reboot with rom seen", int'(reboot_req), 1);

        // R6: halt freezes the counter
        wr(1, 1);
        rd(3, c0);
        repeat (6) step();
        rd(3, v); check("R6 count frozen", v, c0);
        rd(2, v); check("R6 status unchanged", v, 3);
        // R7: write-one-to-clear
        wr(2, 2);
        rd(2, v); check("R7 clear bit1 only", v, 1);
        wr(2, 0);
        rd(2, v); check("R7 zero write no effect", v, 1);
        wr(2, 1);
        rd(2, v); check("R7 clear bit0", v, 0);
        repeat (8) step();
        rd(2, v); check("R6 no set while halted", v, 0);
        rd(3, v); check("R6 count still frozen", v, c0);

        // R8: set wins over clear (reload 0 expires every cycle)
        wr(1, 0);
        wr(0, 0);
        step();
        step();
        rd(2, v); check("R8 pre status", v, 3);
        wr(2, 3);
        rd(2, v); check("R8 set wins", v, 3);

        // R3: reload write restarts the counter
        do_reset();
        wr(0, 5);
        repeat (3) step();
        rd(3, v); check("R3 count before restart", v, 2);
        wr(0, 4);
        rd(3, v); check("R3 count restarted", v, 4);
        rd(0, v); check("R3 reload stored", v, 4);
        repeat (4) step();
        rd(3, v); check("R2 count at zero", v, 0);
        rd(2, v); check("R4 not yet expired", v, 0);
        step();
        rd(3, v); check("R2 count reloaded", v, 4);
        rd(2, v); check("R4 first timeout", v, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule